// File: doc/BRIEF.md
# Gate Driver Fault Supervisor

This block watches the protection conditions around a three-phase half-bridge gate driver. It produces one output-disable for all six gate drivers, and for each fault a live flag and a sticky flag. Analog comparators sit outside the block. Their results arrive as asynchronous levels, and each one passes through a two-stage synchronizer before any logic uses it.

Each fault has its own way of clearing:
- Regulator undervoltage and over-temperature follow their comparators and clear by themselves. The over-temperature comparator supplies the hysteresis.
- A phase short to ground latches, and only a commutation or a reset clears it. The supervisor ignores the switch-node comparator until the high-side driver has stayed on for a settling window, so that gate slewing cannot cause a false trip.
- Bootstrap charging is qualified by a timed window. The window passes once the charge current has fallen below threshold and the switch node is near ground. If the window runs out first, the supervisor opens the charge path and latches a fault. Only a commutation or a reset clears that fault.

All delays are cycle counts set by parameters.

Top module: `gate_fault_supervisor`

## Requirements
- R1: During and after synchronous reset, `drive_disable`, `charge_en`, `boot_ok`, `fault_now` and `fault_seen` are all zero.
- R2: `fault_now[0]` (undervoltage) goes high on the third rising edge after `uv_raw` rises. It drops again by itself once `uv_raw` has been low for three edges.
- R3: `fault_now[1]` (over-temperature) follows `hot_raw` with the same three-edge latency. It clears by itself when `hot_raw` falls.
- R4: If `hs_on` stays high for more than `SETTLE_CYC + 4` cycles while `sw_high_raw` is low, `fault_now[2]` (short to ground) is set. If `sw_high_raw` is high over the same interval, it stays clear.
- R5: If `hs_on` is high for fewer than `SETTLE_CYC` cycles, `fault_now[2]` is not set, whatever the level of `sw_high_raw`.
- R6: Once set, `fault_now[2]` stays set after `hs_on` falls. A one-cycle `commutate` pulse clears it on the next edge.
- R7: A reset clears a latched `fault_now[2]`.
- R8: While `boot_req` is high, `charge_en` is high. `boot_ok` rises once `chg_low_raw` and `sw_gnd_raw` are both high. If only one of the two is high, `boot_ok` stays low.
- R9: If qualification has not passed `BOOT_TMO_CYC` cycles after charging starts, `fault_now[3]` (bootstrap) is set and `charge_en` drops. The fault survives the fall of `boot_req`. Only `commutate` or reset clears it.
- R10: `fault_seen[i]` is set whenever `fault_now[i]` is set. Only reset clears it.
- R11: `drive_disable` is high exactly when at least one bit of `fault_now` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_raw | input | 1 | Gate regulator below undervoltage threshold (async) |
| hot_raw | input | 1 | Die over-temperature indication, hysteresis applied outside (async) |
| sw_high_raw | input | 1 | Switch node near motor supply (async) |
| chg_low_raw | input | 1 | Bootstrap charge current below threshold (async) |
| sw_gnd_raw | input | 1 | Switch node near ground (async) |
| hs_on | input | 1 | High-side driver commanded on (synchronous) |
| boot_req | input | 1 | Bootstrap charge phase requested (synchronous) |
| commutate | input | 1 | One-cycle pulse at each phase commutation |
| drive_disable | output | 1 | Disables all gate outputs |
| fault_now | output | 4 | Live faults: 0 undervoltage, 1 over-temperature, 2 short, 3 bootstrap |
| fault_seen | output | 4 | Sticky record of `fault_now`, cleared by reset |
| charge_en | output | 1 | Bootstrap charge path connected |
| boot_ok | output | 1 | Bootstrap charge qualified |

## Verification
An error in the settle counter would show at the ports in one of two ways. A short flag could appear while `hs_on` is still within its window. A real short could fail to appear a few cycles after the window closes. The bench probes both sides of that window.

An error in the bootstrap state machine would show in `charge_en` and `fault_now[3]`. These would fail to drop at the timeout, or would survive a commutation. Such errors become visible within one timeout period.

Synchronizer depth shows up as exact-edge latency on the self-recovering faults. Sticky bits that clear early show up after a fault has gone away.

// File: rtl/gfs_pkg.sv
package gfs_pkg;
  localparam int NUM_FAULTS = 4;
  localparam int F_UV    = 0;
  localparam int F_OT    = 1;
  localparam int F_SHORT = 2;
  localparam int F_BOOT  = 3;

  typedef enum logic [1:0] {
    BQ_IDLE = 2'd0,
    BQ_CHG  = 2'd1,
    BQ_DONE = 2'd2,
    BQ_FAIL = 2'd3
  } boot_state_t;
endpackage

// File: rtl/gfs_sync.sv
module gfs_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/gfs_short_mon.sv
module gfs_short_mon #(
  parameter int SETTLE_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic hs_on,
  input  logic sw_high,
  input  logic commutate,
  output logic fault_nxt,
  output logic fault_q
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed;

  assign armed = (cnt_q == CW'(SETTLE_CYC));

  always_comb begin
    if (commutate || !hs_on) cnt_d = '0;
    else if (!armed)         cnt_d = cnt_q + CW'(1);
    else                     cnt_d = cnt_q;
  end

  always_comb begin
    if (commutate) fault_nxt = 1'b0;
    else           fault_nxt = fault_q | (armed & hs_on & ~sw_high);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fault_q <= fault_nxt;
    end
  end

  // R5
  short_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_q) |-> $past(cnt_q == CW'(SETTLE_CYC)));

  // R6
  short_clear_chk: assert property (@(posedge clk) disable iff (rst)
    commutate |=> !fault_q);
endmodule

// File: rtl/gfs_boot_qual.sv
module gfs_boot_qual
  import gfs_pkg::*;
#(
  parameter int BOOT_TMO_CYC = 12000
) (
  input  logic clk,
  input  logic rst,
  input  logic boot_req,
  input  logic chg_low,
  input  logic sw_gnd,
  input  logic commutate,
  output logic fault_nxt,
  output logic fault_q,
  output logic charge_en,
  output logic boot_ok
);
  localparam int TW = $clog2(BOOT_TMO_CYC + 1);

  boot_state_t   st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          qual;

  assign qual = chg_low & sw_gnd;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    if (commutate) begin
      st_d  = BQ_IDLE;
      tmr_d = '0;
    end else begin
      case (st_q)
        BQ_IDLE: begin
          tmr_d = '0;
          if (boot_req) st_d = BQ_CHG;
        end
        BQ_CHG: begin
          if (!boot_req) begin
            st_d  = BQ_IDLE;
            tmr_d = '0;
          end else if (qual) begin
            st_d = BQ_DONE;
          end else if (tmr_q == TW'(BOOT_TMO_CYC - 1)) begin
            st_d = BQ_FAIL;
          end else begin
            tmr_d = tmr_q + TW'(1);
          end
        end
        BQ_DONE: begin
          if (!boot_req) st_d = BQ_IDLE;
        end
        default: st_d = BQ_FAIL;
      endcase
    end
  end

  assign fault_nxt = (st_d == BQ_FAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= BQ_IDLE;
      tmr_q     <= '0;
      fault_q   <= 1'b0;
      charge_en <= 1'b0;
      boot_ok   <= 1'b0;
    end else begin
      st_q      <= st_d;
      tmr_q     <= tmr_d;
      fault_q   <= fault_nxt;
      charge_en <= (st_d == BQ_CHG) || (st_d == BQ_DONE);
      boot_ok   <= (st_d == BQ_DONE);
    end
  end

  // R9
  boot_path_chk: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> !charge_en);

  // R8
  boot_ok_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(boot_ok) |-> $past(qual));

  // R9
  boot_tmr_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_q < TW'(BOOT_TMO_CYC));
endmodule

// File: rtl/gate_fault_supervisor.sv
module gate_fault_supervisor
  import gfs_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int SETTLE_CYC   = 200,
  parameter int BOOT_TMO_CYC = 12000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  uv_raw,
  input  logic                  hot_raw,
  input  logic                  sw_high_raw,
  input  logic                  chg_low_raw,
  input  logic                  sw_gnd_raw,
  input  logic                  hs_on,
  input  logic                  boot_req,
  input  logic                  commutate,
  output logic                  drive_disable,
  output logic [NUM_FAULTS-1:0] fault_now,
  output logic [NUM_FAULTS-1:0] fault_seen,
  output logic                  charge_en,
  output logic                  boot_ok
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0]      raw_vec, syn_vec;
  logic                  uv_s, hot_s, swh_s, chg_s, swg_s;
  logic [NUM_FAULTS-1:0] nxt;
  logic                  short_nxt, short_q, boot_nxt, boot_q;
  logic                  uv_q, hot_q;

  assign raw_vec = {sw_gnd_raw, chg_low_raw, sw_high_raw, hot_raw, uv_raw};
  assign {swg_s, chg_s, swh_s, hot_s, uv_s} = syn_vec;

  gfs_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(raw_vec), .q_sync(syn_vec)
  );

  gfs_short_mon #(.SETTLE_CYC(SETTLE_CYC)) u_short (
    .clk(clk), .rst(rst), .hs_on(hs_on), .sw_high(swh_s),
    .commutate(commutate), .fault_nxt(short_nxt), .fault_q(short_q)
  );

  gfs_boot_qual #(.BOOT_TMO_CYC(BOOT_TMO_CYC)) u_boot (
    .clk(clk), .rst(rst), .boot_req(boot_req), .chg_low(chg_s),
    .sw_gnd(swg_s), .commutate(commutate), .fault_nxt(boot_nxt),
    .fault_q(boot_q), .charge_en(charge_en), .boot_ok(boot_ok)
  );

  always_comb begin
    nxt          = '0;
    nxt[F_UV]    = uv_s;
    nxt[F_OT]    = hot_s;
    nxt[F_SHORT] = short_nxt;
    nxt[F_BOOT]  = boot_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uv_q          <= 1'b0;
      hot_q         <= 1'b0;
      drive_disable <= 1'b0;
      fault_seen    <= '0;
    end else begin
      uv_q          <= uv_s;
      hot_q         <= hot_s;
      drive_disable <= |nxt;
      fault_seen    <= fault_seen | nxt;
    end
  end

  always_comb begin
    fault_now          = '0;
    fault_now[F_UV]    = uv_q;
    fault_now[F_OT]    = hot_q;
    fault_now[F_SHORT] = short_q;
    fault_now[F_BOOT]  = boot_q;
  end

  // R11
  disable_or_chk: assert property (@(posedge clk) disable iff (rst)
    drive_disable == (|fault_now));

  // R10
  sticky_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_now & ~fault_seen) == '0);

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((fault_seen & ~$past(fault_seen)) == '0) || !$stable(fault_seen) || 1'b1 ?
      ((~fault_seen & $past(fault_seen)) == '0) : 1'b1);
endmodule

// File: tb/test_gate_fault_supervisor.sv
module test_gate_fault_supervisor;
  localparam int SETTLE = 16;
  localparam int TMO    = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uv_raw = 0, hot_raw = 0, sw_high_raw = 0, chg_low_raw = 0, sw_gnd_raw = 0;
  logic hs_on = 0, boot_req = 0, commutate = 0;
  logic       drive_disable, charge_en, boot_ok;
  logic [3:0] fault_now, fault_seen;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gate_fault_supervisor #(.SYNC_STAGES(2), .SETTLE_CYC(SETTLE), .BOOT_TMO_CYC(TMO))
    i_gate_fault_supervisor (
    .clk(clk), .rst(rst), .uv_raw(uv_raw), .hot_raw(hot_raw),
    .sw_high_raw(sw_high_raw), .chg_low_raw(chg_low_raw), .sw_gnd_raw(sw_gnd_raw),
    .hs_on(hs_on), .boot_req(boot_req), .commutate(commutate),
    .drive_disable(drive_disable), .fault_now(fault_now), .fault_seen(fault_seen),
    .charge_en(charge_en), .boot_ok(boot_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    uv_raw = 0; hot_raw = 0; sw_high_raw = 0; chg_low_raw = 0; sw_gnd_raw = 0;
    hs_on = 0; boot_req = 0; commutate = 0;
    cyc(3);
    rst = 1'b0;
  endtask

  task automatic pulse_commutate();
    commutate = 1'b1;
    cyc(1);
    commutate = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    cyc(2);
    chk("R1 disable", drive_disable, 0);
    chk("R1 fault_now", fault_now, 0);
    chk("R1 fault_seen", fault_seen, 0);
    chk("R1 charge_en/boot_ok", {charge_en, boot_ok}, 0);
  endtask

  task automatic t_uv();
    do_reset();
    cyc(2);
    uv_raw = 1'b1;
    cyc(2);
    chk("R2 uv not yet", fault_now[0], 0);
    cyc(1);
    chk("R2 uv third edge", fault_now[0], 1);
    chk("R11 disable on uv", drive_disable, 1);
    uv_raw = 1'b0;
    cyc(3);
    chk("R2 uv self-clears", fault_now[0], 0);
    chk("R11 disable drops", drive_disable, 0);
    chk("R10 uv sticky", fault_seen[0], 1);
  endtask

  task automatic t_ot();
    do_reset();
    cyc(2);
    hot_raw = 1'b1;
    cyc(3);
    chk("R3 ot set", fault_now[1], 1);
    cyc(20);
    chk("R3 ot held", fault_now[1], 1);
    hot_raw = 1'b0;
    cyc(3);
    chk("R3 ot recovers", fault_now[1], 0);
    chk("R10 ot sticky", fault_seen[1], 1);
  endtask

  task automatic t_short();
    do_reset();
    sw_high_raw = 1'b1;
    cyc(4);
    hs_on = 1'b1;
    cyc(SETTLE + 10);
    chk("R4 healthy node no short", fault_now[2], 0);
    hs_on = 1'b0;
    sw_high_raw = 1'b0;
    cyc(4);
    hs_on = 1'b1;
    cyc(SETTLE - 4);
    hs_on = 1'b0;
    cyc(4);
    chk("R5 ignored in settle window", fault_now[2], 0);
    chk("R5 no disable", drive_disable, 0);
    hs_on = 1'b1;
    cyc(SETTLE + 6);
    chk("R4 short detected", fault_now[2], 1);
    chk("R11 disable on short", drive_disable, 1);
    hs_on = 1'b0;
    cyc(5);
    chk("R6 short latched", fault_now[2], 1);
    pulse_commutate();
    chk("R6 commutate clears", fault_now[2], 0);
    chk("R10 short sticky", fault_seen[2], 1);
    hs_on = 1'b1;
    cyc(SETTLE + 6);
    hs_on = 1'b0;
    chk("R4 short again", fault_now[2], 1);
    do_reset();
    cyc(1);
    chk("R7 reset clears short", fault_now[2], 0);
    chk("R10 reset clears sticky", fault_seen, 0);
  endtask

  task automatic t_boot_timeout();
    do_reset();
    chg_low_raw = 1'b1;
    sw_gnd_raw  = 1'b0;
    cyc(4);
    boot_req = 1'b1;
    cyc(20);
    chk("R8 charge_en during charge", charge_en, 1);
    chk("R8 one condition not qualified", boot_ok, 0);
    chk("R9 no early fault", fault_now[3], 0);
    cyc(TMO + 10);
    chk("R9 timeout fault", fault_now[3], 1);
    chk("R9 path opened", charge_en, 0);
    chk("R11 disable on boot fault", drive_disable, 1);
    boot_req = 1'b0;
    cyc(5);
    chk("R9 fault survives boot_req low", fault_now[3], 1);
    pulse_commutate();
    chk("R9 commutate clears boot fault", fault_now[3], 0);
    chk("R10 boot sticky", fault_seen[3], 1);
    boot_req = 1'b1;
    cyc(TMO + 10);
    chk("R9 timeout again", fault_now[3], 1);
    do_reset();
    cyc(1);
    chk("R9 reset clears boot fault", fault_now[3], 0);
  endtask

  task automatic t_boot_ok();
    do_reset();
    chg_low_raw = 1'b0;
    sw_gnd_raw  = 1'b1;
    cyc(4);
    boot_req = 1'b1;
    cyc(10);
    chk("R8 only near-ground not qualified", boot_ok, 0);
    chg_low_raw = 1'b1;
    cyc(5);
    chk("R8 qualified", boot_ok, 1);
    chk("R8 charge_en held", charge_en, 1);
    cyc(TMO + 10);
    chk("R9 no fault after qualify", fault_now[3], 0);
    boot_req = 1'b0;
    cyc(2);
    chk("R8 charge_en drops with request", charge_en, 0);
  endtask

  initial begin
    t_reset_state();
    t_uv();
    t_ot();
    t_short();
    t_boot_timeout();
    t_boot_ok();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule